// File: doc/BRIEF.md
# SPI Chip-Select Delay Sequencer

This block paces the chip-select line of an SPI master around every frame. When a frame is requested and the bus is free, it asserts chip-select. When the shifter reports that the final serial-clock edge of the frame has happened, it holds chip-select asserted for a programmable trailing interval. It then releases chip-select and enforces a programmable idle gap before any later frame may assert chip-select again.

Each interval is a product of two factors, each picked by a small code field. A 2-bit prescaler code selects an odd factor. A 4-bit scaler code selects a power of two. The pair of codes for the trailing interval is independent of the pair for the idle gap. A frame request that arrives while a frame or one of its intervals is in progress is remembered. It is served as soon as the gap ends. Serial-clock generation and data shifting belong to neighbouring logic.

Top module: `cs_gap_sequencer`

## Requirements
- R1: After a synchronous active-high reset, `cs_active` is 0, `cs_ready` is 1 and `delay_busy` is 0.
- R2: Prescaler code c (2 bits) selects the factor 2c+1: 00→1, 01→3, 10→5, 11→7.
- R3: Scaler code n (4 bits) selects the factor 2^(n+1): 0000→2, up to 1111→65536.
- R4: If `last_edge` is high in a cycle where `cs_active` is 1 and `delay_busy` is 0, `cs_active` stays 1 for exactly Pt·St further cycles and then drops. Pt and St come from `trail_pre` and `trail_scl`.
- R5: After `cs_active` drops, `delay_busy` stays 1 for exactly Pg·Sg cycles. Pg and Sg come from `gap_pre` and `gap_scl`. Then `cs_ready` becomes 1. `cs_active` is never asserted in a cycle unless `cs_ready` was 1 in the cycle before.
- R6: `delay_busy` is 1 during the trailing interval and the gap, and 0 otherwise. `cs_ready` and `delay_busy` are never 1 together.
- R7: A `frame_req` pulse seen while `cs_ready` is 0 is held. `cs_active` then rises one cycle after `cs_ready` next becomes 1.
- R8: All four code inputs are sampled in the cycle `last_edge` is accepted. Changes to them later in that sequence do not alter either interval.
- R9: `last_edge` has no effect unless a frame is in progress (`cs_active` 1 and `delay_busy` 0). In idle or during either interval, it leaves the outputs and the interval lengths unchanged.
- R10: A `frame_req` while `cs_ready` is 1 makes `cs_active` 1 and `cs_ready` 0 in the next cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| trail_pre | input | 2 | Prescaler code of the trailing interval |
| trail_scl | input | 4 | Scaler code of the trailing interval |
| gap_pre | input | 2 | Prescaler code of the idle gap |
| gap_scl | input | 4 | Scaler code of the idle gap |
| last_edge | input | 1 | One-cycle strobe: final serial-clock edge of the frame done |
| frame_req | input | 1 | One-cycle strobe: a next frame is pending |
| cs_active | output | 1 | Chip-select asserted (1) or negated (0) |
| delay_busy | output | 1 | A trailing interval or idle gap is running |
| cs_ready | output | 1 | Gap satisfied, chip-select may be asserted |

## Verification
The bench sweeps every prescaler code against the low scaler codes for both intervals, plus one larger scaler code. It measures each interval in cycles. An off-by-one in either counter, or a swapped prescaler/scaler decode, shows up as a length that differs from Pt·St or Pg·Sg. Codes are changed right after the final edge is accepted, so a design that reads them live lengthens or shortens the interval. A request pulsed mid-sequence must reassert chip-select right after the gap; a design without a pending latch would stay idle. Stray final-edge strobes in idle and in the gap would restart a timer or re-enter a frame in a faulty design.

// File: rtl/cs_gap_pkg.sv
package cs_gap_pkg;
   typedef enum logic [1:0] {
      ST_IDLE  = 2'd0,
      ST_FRAME = 2'd1,
      ST_TRAIL = 2'd2,
      ST_GAP   = 2'd3
   } seq_state_t;

   localparam int unsigned NUM_DELAYS = 2;
   localparam int unsigned IDX_TRAIL  = 0;
   localparam int unsigned IDX_GAP    = 1;
endpackage

// File: rtl/cs_delay_decode.sv
// Converts a prescaler code and a scaler code into terminal counts (factor - 1).
module cs_delay_decode #(
   parameter int unsigned PRE_W  = 2,
   parameter int unsigned SCL_W  = 4,
   parameter int unsigned PCNT_W = PRE_W + 1,
   parameter int unsigned SCNT_W = 2 ** SCL_W
) (
   input  logic [PRE_W-1:0]  pre_code,
   input  logic [SCL_W-1:0]  scl_code,
   output logic [PCNT_W-1:0] pre_last,
   output logic [SCNT_W-1:0] scl_last
);
   localparam logic [SCNT_W-1:0] ALL_ONES = {SCNT_W{1'b1}};

   // odd factor 2c+1 -> terminal count 2c
   always_comb begin
      pre_last = '0;
      pre_last[PCNT_W-1:1] = pre_code;
   end

   // power-of-two factor 2^(n+1) -> terminal count 2^(n+1)-1
   always_comb begin
      scl_last = ALL_ONES >> (SCNT_W - 1 - int'(scl_code));
   end
endmodule

// File: rtl/cs_delay_timer.sv
// Prescaler counter gating a scaler counter; done marks the final cycle of the interval.
module cs_delay_timer #(
   parameter int unsigned PCNT_W = 3,
   parameter int unsigned SCNT_W = 16
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              start,
   input  logic              run,
   input  logic [PCNT_W-1:0] pre_last,
   input  logic [SCNT_W-1:0] scl_last,
   output logic              done
);
   logic [PCNT_W-1:0] pcnt_q, plim_q;
   logic [SCNT_W-1:0] scnt_q, slim_q;
   logic              pre_wrap;

   assign pre_wrap = (pcnt_q == plim_q);
   assign done     = run && pre_wrap && (scnt_q == slim_q);

   always_ff @(posedge clk) begin
      if (rst) begin
         pcnt_q <= '0;
         scnt_q <= '0;
         plim_q <= '0;
         slim_q <= '0;
      end else if (start) begin
         pcnt_q <= '0;
         scnt_q <= '0;
         plim_q <= pre_last;
         slim_q <= scl_last;
      end else if (run) begin
         if (pre_wrap) begin
            pcnt_q <= '0;
            if (scnt_q != slim_q) begin
               scnt_q <= scnt_q + 1'b1;
            end
         end else begin
            pcnt_q <= pcnt_q + 1'b1;
         end
      end
   end
endmodule

// File: rtl/cs_gap_sequencer.sv
module cs_gap_sequencer #(
   parameter int unsigned PRE_W = 2,
   parameter int unsigned SCL_W = 4
) (
   input  logic             clk,
   input  logic             rst,
   input  logic [PRE_W-1:0] trail_pre,
   input  logic [SCL_W-1:0] trail_scl,
   input  logic [PRE_W-1:0] gap_pre,
   input  logic [SCL_W-1:0] gap_scl,
   input  logic             last_edge,
   input  logic             frame_req,
   output logic             cs_active,
   output logic             delay_busy,
   output logic             cs_ready
);
   import cs_gap_pkg::*;

   localparam int unsigned PCNT_W = PRE_W + 1;
   localparam int unsigned SCNT_W = 2 ** SCL_W;

   if (PRE_W < 1 || PRE_W > 4) begin : g_bad_pre
      $error("cs_gap_sequencer: PRE_W must lie in 1..4");
   end
   if (SCL_W < 1 || SCL_W > 5) begin : g_bad_scl
      $error("cs_gap_sequencer: SCL_W must lie in 1..5");
   end

   seq_state_t state_q, state_d;
   logic       pend_q;
   logic       go, accept_edge, timer_done, timer_start, timer_run;

   // gap codes captured with the final edge; trailing codes go straight into the timer
   logic [PRE_W-1:0] gap_pre_q;
   logic [SCL_W-1:0] gap_scl_q;

   logic [PRE_W-1:0]  dec_pre  [NUM_DELAYS];
   logic [SCL_W-1:0]  dec_scl  [NUM_DELAYS];
   logic [PCNT_W-1:0] pre_last [NUM_DELAYS];
   logic [SCNT_W-1:0] scl_last [NUM_DELAYS];
   logic [PCNT_W-1:0] sel_pre;
   logic [SCNT_W-1:0] sel_scl;

   assign dec_pre[IDX_TRAIL] = trail_pre;
   assign dec_scl[IDX_TRAIL] = trail_scl;
   assign dec_pre[IDX_GAP]   = gap_pre_q;
   assign dec_scl[IDX_GAP]   = gap_scl_q;

   for (genvar i = 0; i < NUM_DELAYS; i++) begin : g_dec
      cs_delay_decode #(
         .PRE_W (PRE_W),
         .SCL_W (SCL_W),
         .PCNT_W(PCNT_W),
         .SCNT_W(SCNT_W)
      ) u_dec (
         .pre_code(dec_pre[i]),
         .scl_code(dec_scl[i]),
         .pre_last(pre_last[i]),
         .scl_last(scl_last[i])
      );
   end

   assign go          = (state_q == ST_IDLE) && (frame_req || pend_q);
   assign accept_edge = (state_q == ST_FRAME) && last_edge;
   assign timer_run   = (state_q == ST_TRAIL) || (state_q == ST_GAP);
   assign timer_start = accept_edge || ((state_q == ST_TRAIL) && timer_done);

   always_comb begin
      if (state_q == ST_FRAME) begin
         sel_pre = pre_last[IDX_TRAIL];
         sel_scl = scl_last[IDX_TRAIL];
      end else begin
         sel_pre = pre_last[IDX_GAP];
         sel_scl = scl_last[IDX_GAP];
      end
   end

   cs_delay_timer #(
      .PCNT_W(PCNT_W),
      .SCNT_W(SCNT_W)
   ) u_timer (
      .clk     (clk),
      .rst     (rst),
      .start   (timer_start),
      .run     (timer_run),
      .pre_last(sel_pre),
      .scl_last(sel_scl),
      .done    (timer_done)
   );

   always_comb begin
      state_d = state_q;
      unique case (state_q)
         ST_IDLE:  if (go)          state_d = ST_FRAME;
         ST_FRAME: if (accept_edge) state_d = ST_TRAIL;
         ST_TRAIL: if (timer_done)  state_d = ST_GAP;
         ST_GAP:   if (timer_done)  state_d = ST_IDLE;
         default:                   state_d = ST_IDLE;
      endcase
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         state_q   <= ST_IDLE;
         pend_q    <= 1'b0;
         gap_pre_q <= '0;
         gap_scl_q <= '0;
      end else begin
         state_q <= state_d;
         if (state_q == ST_IDLE) begin
            pend_q <= 1'b0;
         end else if (frame_req) begin
            pend_q <= 1'b1;
         end
         if (accept_edge) begin
            gap_pre_q <= gap_pre;
            gap_scl_q <= gap_scl;
         end
      end
   end

   assign cs_active  = (state_q == ST_FRAME) || (state_q == ST_TRAIL);
   assign delay_busy = timer_run;
   assign cs_ready   = (state_q == ST_IDLE);
endmodule

// File: rtl/cs_gap_sequencer_chk.sv
module cs_gap_sequencer_chk (
   input logic clk,
   input logic rst,
   input logic last_edge,
   input logic frame_req,
   input logic cs_active,
   input logic delay_busy,
   input logic cs_ready
);
   a_r6_ready_busy_excl: assert property (@(posedge clk) disable iff (rst)
      !(cs_ready && delay_busy));

   a_r10_req_asserts_cs: assert property (@(posedge clk) disable iff (rst)
      (cs_ready && frame_req) |=> (cs_active && !cs_ready));

   a_r5_rise_after_ready: assert property (@(posedge clk) disable iff (rst)
      $rose(cs_active) |-> $past(cs_ready));

   a_r4_fall_into_gap: assert property (@(posedge clk) disable iff (rst)
      $fell(cs_active) |-> delay_busy);

   a_r9_edge_starts_trail: assert property (@(posedge clk) disable iff (rst)
      (cs_active && !delay_busy && last_edge) |=> (cs_active && delay_busy));

   a_r9_idle_edge_ignored: assert property (@(posedge clk) disable iff (rst)
      (cs_ready && !frame_req && last_edge) |=> (!cs_active && !delay_busy));

   a_r6_gap_ends_ready: assert property (@(posedge clk) disable iff (rst)
      (!cs_active && delay_busy) |=> (delay_busy || cs_ready));
endmodule

bind cs_gap_sequencer cs_gap_sequencer_chk u_chk (.*);

// File: tb/cs_gap_sequencer_tb.sv
module cs_gap_sequencer_tb_top;
   logic       clk = 1'b0;
   logic       rst = 1'b1;
   logic [1:0] trail_pre = '0;
   logic [3:0] trail_scl = '0;
   logic [1:0] gap_pre = '0;
   logic [3:0] gap_scl = '0;
   logic       last_edge = 1'b0;
   logic       frame_req = 1'b0;
   logic       cs_active, delay_busy, cs_ready;

   int n_chk = 0;
   int n_bad = 0;
   bit finished = 1'b0;

   always #5 clk = ~clk;

   cs_gap_sequencer dut_i (
      .clk(clk), .rst(rst),
      .trail_pre(trail_pre), .trail_scl(trail_scl),
      .gap_pre(gap_pre), .gap_scl(gap_scl),
      .last_edge(last_edge), .frame_req(frame_req),
      .cs_active(cs_active), .delay_busy(delay_busy), .cs_ready(cs_ready)
   );

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      n_chk++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   function automatic int pre_f(input int c);
      return 2 * c + 1;
   endfunction

   function automatic int scl_f(input int n);
      return 1 << (n + 1);
   endfunction

   // one complete frame; optionally scramble codes (R8), pulse a request mid-trail (R7)
   // and strobe last_edge during the gap (R9)
   task automatic frame(input int tp, input int ts, input int gp, input int gs,
                        input bit extra_req, input bit stray_edge);
      int cnt, exp_t, exp_g;
      exp_t = pre_f(tp) * scl_f(ts);
      exp_g = pre_f(gp) * scl_f(gs);
      if (cs_ready) begin
         frame_req = 1'b1;
         @(negedge clk);
         frame_req = 1'b0;
      end
      chk(cs_active && !cs_ready, "R10 cs after request", cs_active, 1);
      repeat (2) @(negedge clk);
      trail_pre = 2'(tp); trail_scl = 4'(ts);
      gap_pre = 2'(gp); gap_scl = 4'(gs);
      last_edge = 1'b1;
      @(negedge clk);
      last_edge = 1'b0;
      trail_pre = ~trail_pre; trail_scl = 4'(ts + 1);
      gap_pre = ~gap_pre; gap_scl = 4'(gs + 1);
      cnt = 0;
      while (cs_active) begin
         if (!delay_busy) chk(1'b0, "R6 busy in trail", 0, 1);
         if (cnt == 1 && extra_req) frame_req = 1'b1;
         cnt++;
         @(negedge clk);
         frame_req = 1'b0;
      end
      chk(cnt == exp_t, "R4 R2 R3 R8 trail length", cnt, exp_t);
      cnt = 0;
      while (delay_busy) begin
         if (cnt == 1 && stray_edge) last_edge = 1'b1;
         cnt++;
         @(negedge clk);
         last_edge = 1'b0;
      end
      chk(cnt == exp_g, "R5 R2 R3 R8 gap length", cnt, exp_g);
      chk(cs_ready && !cs_active, "R5 ready after gap", cs_ready, 1);
      if (extra_req) begin
         @(negedge clk);
         chk(cs_active == 1'b1, "R7 held request served", cs_active, 1);
      end
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst = 1'b0;
      chk(!cs_active && cs_ready && !delay_busy, "R1 reset state", cs_active, 0);
      // R9: final-edge strobe in idle is ignored
      last_edge = 1'b1;
      @(negedge clk);
      last_edge = 1'b0;
      @(negedge clk);
      chk(!cs_active && cs_ready && !delay_busy, "R9 idle edge ignored", delay_busy, 0);
      // R2 R3 sweep of the trailing interval
      for (int p = 0; p < 4; p++)
         for (int s = 0; s < 5; s++)
            frame(p, s, 0, 0, 1'b0, 1'b0);
      // R2 R3 sweep of the gap
      for (int p = 0; p < 4; p++)
         for (int s = 0; s < 5; s++)
            frame(0, 0, p, s, 1'b0, 1'b0);
      // larger scaler code
      frame(1, 9, 2, 6, 1'b0, 1'b0);
      // R7 held request, R9 stray edge during gap
      frame(1, 1, 1, 2, 1'b1, 1'b1);
      frame(2, 0, 3, 1, 1'b0, 1'b1);
      // reset mid-frame returns to R1 state
      frame_req = 1'b1;
      @(negedge clk);
      frame_req = 1'b0;
      rst = 1'b1;
      @(negedge clk);
      rst = 1'b0;
      chk(!cs_active && cs_ready && !delay_busy, "R1 reset mid-frame", cs_active, 0);
      if (!finished) begin
         finished = 1'b1;
         $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
         $finish;
      end
   end

   initial begin
      repeat (190000) @(posedge clk);
      if (!finished) begin
         finished = 1'b1;
         n_chk++;
         n_bad++;
         $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
         $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
         $finish;
      end
   end
endmodule